// File: doc/BRIEF.md
# Main Clock Safeguard with Auxiliary Failover

This block sits between an external main clock pin and the clock that feeds the core. A supervision reference clock oversamples both the main clock and a slow auxiliary clock. The core clock is rebuilt from those samples. When the safeguard option input is high, three things happen. Main-clock pulses that would push the core faster than the allowed rate are held back, so no core phase is ever shorter than a minimum number of reference cycles. A stopped main clock is detected by a missing-edge timer. The core is then moved to the auxiliary clock, and it moves back only after the main clock has shown a steady run of edges again.

Each change of source is made while the core clock is low. The outgoing source is parked low first. The incoming source is gated on only once it is itself low. A status pin reports when the auxiliary clock drives the core. When the option input is low, the main clock passes straight through to the core clock and the auxiliary path is unused.

The block carries no data stream, so it has no valid/ready handshake and no back-pressure. All of its pins are plain clock, control or status lines.

Top module: `clk_guard`

## Requirements
- R1: While reset is asserted with the option high, `clk_core` is 0, `aux_active` is 0 and the main clock is the selected source.
- R2: With `guard_en` low, `clk_core` equals `clk_main` at all times, with no register in the path.
- R3: With `guard_en` high and the main clock healthy and slower than the limit, a level of `clk_main` captured at reference edge k appears on `clk_core` from reference edge k+SYNC_STAGES+1 onward.
- R4: While the main clock drives the core, every high phase of the core clock lasts at least MIN_HIGH reference cycles and every low phase at least MIN_LOW. A main-clock change that arrives sooner is postponed until the minimum has passed, which caps the core frequency.
- R5: When the synchronised main clock shows no edge for MISS_LIMIT consecutive reference cycles, `clk_core` is forced low at the next reference edge. The auxiliary clock then takes over at the first reference edge where its synchronised level is low.
- R6: `aux_active` is 1 exactly while the auxiliary clock is the gated source of `clk_core`, and 0 while the main clock drives it or while the core is parked between sources.
- R7: The core returns to the main clock only after RESTART_EDGES consecutive valid main edges. A valid edge is one seen within MISS_LIMIT reference cycles of the previous one. A shorter burst followed by another stop leaves the auxiliary clock in charge.
- R8: Every source change happens while `clk_core` is low. `aux_active` changes only in reference cycles where `clk_core` is 0. On the way back, the core stays low until the auxiliary clock is low and the filtered main clock is low.
- R9: The auxiliary clock never drives the core while `guard_en` is low: `aux_active` stays 0 even if the main clock stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Supervision reference clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| guard_en | input | 1 | Safeguard option; high enables filtering and failover |
| clk_main | input | 1 | External main clock, sampled by `clk_ref` |
| clk_aux | input | 1 | Free-running low-frequency auxiliary clock, sampled by `clk_ref` |
| clk_core | output | 1 | Internal core clock |
| aux_active | output | 1 | 1 while the auxiliary clock drives `clk_core` |

## Verification
Each `clk_main` level reaches `clk_core` three reference edges after the edge that samples it: two synchroniser stages, then the phase shaper, then the output register. A failover shows one edge after the missing-edge counter saturates, and `aux_active` moves in the same edge as the source gate. The bench runs a behavioural model that takes inputs at the same rising edge as the design. Both outputs are compared one nanosecond after every rising edge, when the design and the model have settled and no input is moving, because stimulus changes only on falling edges. Phase-length, status and burst checks are built on those same sampled values, so no result depends on event order at an edge.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;

  typedef enum logic [2:0] {
    SRC_MAIN      = 3'd0,
    SRC_ARM_AUX   = 3'd1,
    SRC_AUX       = 3'd2,
    SRC_LEAVE_AUX = 3'd3,
    SRC_ARM_MAIN  = 3'd4
  } src_state_e;

  function automatic logic aux_gated(input src_state_e s);
    return (s == SRC_AUX) || (s == SRC_LEAVE_AUX);
  endfunction

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/cg_phase_shaper.sv
module cg_phase_shaper #(
  parameter int MIN_HIGH = 2,
  parameter int MIN_LOW  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic lvl_i,
  output logic lvl_o
);

  localparam int HOLD_TOP = ((MIN_HIGH > MIN_LOW) ? MIN_HIGH : MIN_LOW) - 1;
  localparam int HW       = $clog2(HOLD_TOP + 2);
  localparam logic [HW-1:0] HOLD_SAT = HW'(HOLD_TOP);
  localparam logic [HW-1:0] HI_NEED  = HW'(MIN_HIGH - 1);
  localparam logic [HW-1:0] LO_NEED  = HW'(MIN_LOW - 1);

  logic          lvl_q;
  logic [HW-1:0] held_q;
  logic [HW-1:0] need;
  logic          may_flip;

  assign need     = lvl_q ? HI_NEED : LO_NEED;
  assign may_flip = (lvl_i != lvl_q) && (held_q >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      held_q <= HOLD_SAT;
    end else if (!run_i) begin
      lvl_q  <= 1'b0;
      held_q <= HOLD_SAT;
    end else if (may_flip) begin
      lvl_q  <= lvl_i;
      held_q <= '0;
    end else if (held_q < HOLD_SAT) begin
      held_q <= held_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;

  generate
    if (MIN_HIGH >= 2 && MIN_LOW >= 2) begin : g_phase_chk
      AST_NO_SHORT_PHASE: assert property (@(posedge clk) disable iff (!rst_n || !run_i)
        ((lvl_q != $past(lvl_q)) && $past(run_i) && $past(run_i, 2)) |-> ($past(lvl_q) == $past(lvl_q, 2))); // R4
    end
  endgenerate

endmodule

// File: rtl/cg_edge_monitor.sv
module cg_edge_monitor #(
  parameter int MISS_LIMIT    = 4,
  parameter int RESTART_EDGES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic lvl_i,
  output logic starved_o,
  output logic restored_o
);

  localparam int GW = $clog2(MISS_LIMIT + 1);
  localparam int RW = $clog2(RESTART_EDGES + 1);
  localparam logic [GW-1:0] GAP_TOP = GW'(MISS_LIMIT);
  localparam logic [RW-1:0] RUN_TOP = RW'(RESTART_EDGES);

  logic          prev_q;
  logic [GW-1:0] gap_q;
  logic [RW-1:0] run_q;
  logic          seen_edge;

  assign seen_edge  = lvl_i ^ prev_q;
  assign starved_o  = (gap_q == GAP_TOP);
  assign restored_o = (run_q == RUN_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (!run_i || seen_edge) begin
      gap_q <= '0;
    end else if (gap_q < GAP_TOP) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!run_i || starved_o) begin
      run_q <= '0;
    end else if (seen_edge && (run_q < RUN_TOP)) begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_RESTORE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restored_o) |-> $past(seen_edge)); // R7

endmodule

// File: rtl/cg_source_switch.sv
module cg_source_switch
  import clk_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic main_lvl_i,
  input  logic aux_lvl_i,
  input  logic starved_i,
  input  logic restored_i,
  output logic core_o,
  output logic aux_on_o
);

  src_state_e state_q, state_d;
  logic       core_q, aux_q, core_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SRC_MAIN:      if (starved_i) state_d = SRC_ARM_AUX;
      SRC_ARM_AUX:   if (!aux_lvl_i) state_d = SRC_AUX;
      SRC_AUX:       if (restored_i) state_d = SRC_LEAVE_AUX;
      SRC_LEAVE_AUX: begin
        if (starved_i)        state_d = SRC_AUX;
        else if (!aux_lvl_i)  state_d = SRC_ARM_MAIN;
      end
      SRC_ARM_MAIN: begin
        if (starved_i)        state_d = SRC_ARM_AUX;
        else if (!main_lvl_i) state_d = SRC_MAIN;
      end
      default:                state_d = SRC_MAIN;
    endcase
  end

  always_comb begin
    if (state_d == SRC_MAIN)   core_d = main_lvl_i;
    else if (aux_gated(state_d)) core_d = aux_lvl_i;
    else                       core_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRC_MAIN;
      core_q  <= 1'b0;
      aux_q   <= 1'b0;
    end else if (!run_i) begin
      state_q <= SRC_MAIN;
      core_q  <= 1'b0;
      aux_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      core_q  <= core_d;
      aux_q   <= aux_gated(state_d);
    end
  end

  assign core_o   = core_q;
  assign aux_on_o = aux_q;

  AST_SWITCH_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aux_q) |-> !core_q); // R8

  AST_PARK_ON_STARVE: assert property (@(posedge clk) disable iff (!rst_n || !run_i)
    (starved_i && (state_q == SRC_MAIN)) |=> (!core_q || !run_i)); // R5

endmodule

// File: rtl/clk_guard.sv
module clk_guard #(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_HIGH      = 2,
  parameter int MIN_LOW       = 2,
  parameter int MISS_LIMIT    = 4,
  parameter int RESTART_EDGES = 8
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic guard_en,
  input  logic clk_main,
  input  logic clk_aux,
  output logic clk_core,
  output logic aux_active
);

  localparam int N_SRC = 2;

  logic [N_SRC-1:0] raw_lvl, syn_lvl;
  logic main_shaped, starved, restored, core_gated, aux_on;

  assign raw_lvl = {clk_aux, clk_main};

  cg_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_SRC)) u_sync (
    .clk(clk_ref), .rst_n(rst_n), .d_i(raw_lvl), .q_o(syn_lvl)
  );

  cg_phase_shaper #(.MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW)) u_shaper (
    .clk(clk_ref), .rst_n(rst_n), .run_i(guard_en),
    .lvl_i(syn_lvl[0]), .lvl_o(main_shaped)
  );

  cg_edge_monitor #(.MISS_LIMIT(MISS_LIMIT), .RESTART_EDGES(RESTART_EDGES)) u_mon (
    .clk(clk_ref), .rst_n(rst_n), .run_i(guard_en), .lvl_i(syn_lvl[0]),
    .starved_o(starved), .restored_o(restored)
  );

  cg_source_switch u_switch (
    .clk(clk_ref), .rst_n(rst_n), .run_i(guard_en),
    .main_lvl_i(main_shaped), .aux_lvl_i(syn_lvl[1]),
    .starved_i(starved), .restored_i(restored),
    .core_o(core_gated), .aux_on_o(aux_on)
  );

  assign clk_core   = guard_en ? core_gated : clk_main;
  assign aux_active = guard_en & aux_on;

  AST_AUX_NEEDS_OPTION: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !guard_en |=> (!aux_on || guard_en)); // R9

endmodule

// File: tb/sim_clk_guard.sv
module sim_clk_guard;
  localparam int PERIOD  = 10;
  localparam int SYNC    = 2;
  localparam int MIN_H   = 2;
  localparam int MIN_L   = 2;
  localparam int MISS    = 4;
  localparam int RESTART = 8;
  localparam int HMAX    = ((MIN_H > MIN_L) ? MIN_H : MIN_L) - 1;

  logic clk_ref = 0, rst_n = 0, guard_en = 1, clk_main = 0, clk_aux = 0;
  logic clk_core, aux_active;

  clk_guard #(.SYNC_STAGES(SYNC), .MIN_HIGH(MIN_H), .MIN_LOW(MIN_L),
              .MISS_LIMIT(MISS), .RESTART_EDGES(RESTART)) u0 (
    .clk_ref(clk_ref), .rst_n(rst_n), .guard_en(guard_en), .clk_main(clk_main),
    .clk_aux(clk_aux), .clk_core(clk_core), .aux_active(aux_active)
  );

  always #(PERIOD/2) clk_ref = ~clk_ref;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";

  task automatic chk(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input bit ok, input int got, input int exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // stimulus generators, updated on falling edges only
  int main_half = 3;
  bit main_run = 1;
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk_ref);
      if (main_run) begin
        if (cnt >= main_half - 1) begin clk_main = ~clk_main; cnt = 0; end
        else cnt++;
      end
    end
  end
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk_ref);
      if (cnt >= 4) begin clk_aux = ~clk_aux; cnt = 0; end
      else cnt++;
    end
  end

  // behavioural reference model
  int m_ms[SYNC], m_as[SYNC];
  int m_prev, m_fm, m_hold, m_gap, m_run, m_st, m_core, m_aux;
  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) begin m_ms[i] = 0; m_as[i] = 0; end
      m_prev = 0; m_fm = 0; m_hold = HMAX; m_gap = 0; m_run = 0;
      m_st = 0; m_core = 0; m_aux = 0;
    end else begin
      int sm, sa, nfm, nhold, ngap, nrun, nst, lim;
      bit edge_seen, starve, restore;
      sm = m_ms[SYNC-1]; sa = m_as[SYNC-1];
      edge_seen = (sm != m_prev);
      starve = (m_gap == MISS); restore = (m_run == RESTART);
      for (int i = SYNC-1; i > 0; i--) begin m_ms[i] = m_ms[i-1]; m_as[i] = m_as[i-1]; end
      m_ms[0] = clk_main; m_as[0] = clk_aux;
      m_prev = sm;
      if (!guard_en) begin
        m_fm = 0; m_hold = HMAX; m_gap = 0; m_run = 0; m_st = 0; m_core = 0; m_aux = 0;
      end else begin
        lim = m_fm ? MIN_H : MIN_L;
        if (sm != m_fm && m_hold >= lim - 1) begin nfm = sm; nhold = 0; end
        else begin nfm = m_fm; nhold = (m_hold < HMAX) ? m_hold + 1 : m_hold; end
        ngap = edge_seen ? 0 : ((m_gap < MISS) ? m_gap + 1 : m_gap);
        nrun = starve ? 0 : ((edge_seen && m_run < RESTART) ? m_run + 1 : m_run);
        // 0 main, 1 park before aux, 2 aux, 3 aux draining, 4 park before main
        nst = m_st;
        case (m_st)
          0: if (starve) nst = 1;
          1: if (sa == 0) nst = 2;
          2: if (restore) nst = 3;
          3: if (starve) nst = 2; else if (sa == 0) nst = 4;
          default: if (starve) nst = 1; else if (m_fm == 0) nst = 0;
        endcase
        m_core = (nst == 0) ? m_fm : ((nst == 2 || nst == 3) ? sa : 0);
        m_aux  = (nst == 2 || nst == 3);
        m_st = nst; m_fm = nfm; m_hold = nhold; m_gap = ngap; m_run = nrun;
      end
    end
  end

  // per-cycle comparison and derived measurements
  logic last_core = 0, last_aux = 0;
  int phase_len = 0, min_phase = 1000, core_edges = 0;
  bit aux_dropped = 0;
  initial begin
    forever begin
      @(posedge clk_ref); #1;
      if (rst_n) begin
        chk(tag, clk_core, guard_en ? logic'(m_core[0]) : clk_main, "clk_core");
        chk(tag, aux_active, guard_en & logic'(m_aux[0]), "aux_active");
        if (aux_active !== last_aux)
          chk("R8", clk_core, 1'b0, "clk_core during source change");
        if (clk_core !== last_core) begin
          core_edges++;
          if (phase_len < min_phase) min_phase = phase_len;
          phase_len = 1;
        end else phase_len++;
        if (!aux_active) aux_dropped = 1;
      end
      last_core = clk_core; last_aux = aux_active;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state with option high
    cyc(3);
    chk("R1", clk_core, 1'b0, "clk_core in reset");
    chk("R1", aux_active, 1'b0, "aux_active in reset");
    rst_n = 1;
    tag = "R3";
    cyc(60);
    // R2 and R9: option low
    guard_en = 0; tag = "R2";
    cyc(40);
    main_run = 0; tag = "R9";
    cyc(30);
    chk("R9", aux_active, 1'b0, "aux_active with option low and main stopped");
    chk("R2", clk_core, clk_main, "clk_core pass-through");
    main_run = 1; guard_en = 1; tag = "R3";
    cyc(80);
    // R4: over-frequency main clock
    main_half = 1; tag = "R4";
    cyc(10);
    @(posedge clk_ref); #1;
    min_phase = 1000; core_edges = 0; phase_len = 1;
    cyc(60);
    chk_int("R4", min_phase >= MIN_H, min_phase, MIN_H, "shortest core phase");
    chk_int("R4", core_edges >= 10, core_edges, 10, "core edges under fast main");
    main_half = 3; tag = "R3";
    cyc(40);
    // R5/R6: main stops
    main_run = 0; tag = "R5";
    cyc(20);
    chk("R6", aux_active, 1'b1, "aux_active after main stop");
    core_edges = 0;
    cyc(30);
    chk_int("R5", core_edges >= 4, core_edges, 4, "core edges from auxiliary");
    // R7: short burst does not return
    aux_dropped = 0; tag = "R7";
    main_run = 1;
    cyc(9);
    main_run = 0;
    cyc(25);
    chk("R7", aux_dropped, 1'b0, "auxiliary dropped after short burst");
    // R7/R6: steady main returns
    main_run = 1;
    cyc(80);
    chk("R6", aux_active, 1'b0, "aux_active after main restart");
    chk("R7", aux_dropped, 1'b1, "returned to main clock");
    tag = "R3";
    cyc(20);
    finish_run();
  end
endmodule